// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers interrupt requests for a pipelined core. Each source has a flag bit, which captures a rising edge on its event input, and an enable bit. Software can force flags on or off through write-one strobe vectors. A global enable bit gates all acceptance. The block offers the lowest-numbered source that is both flagged and enabled on a valid/ready pair. The core takes it by raising ready.

The core reports every branch it issues. A branch keeps its delay slots in flight for a fixed number of cycles, and no interrupt is offered during that time. Flags stay pending and are offered once the slots have drained. A loop that branches more often than once per (slots + 1) cycles therefore never lets an interrupt in.

Back-pressure rules: `take_valid` and `take_id` are worked out again every cycle from registered state. The offer is a request and not a committed transfer. It may drop, or change to a higher-priority source, before `take_ready` is seen. A transfer happens in exactly the cycle where `take_valid` and `take_ready` are both 1, and it acknowledges the id shown in that cycle. `take_ready` without `take_valid` has no effect.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `flags`, `enables` and `gie` are all 0 and `take_valid` is 0.
- R2: A 0-to-1 change on `evt[i]` between two consecutive clock edges sets `flags[i]` at the second edge. An event input that stays high does not set the flag again after it has been cleared.
- R3: A 1 in `sw_set[i]` sets `flags[i]` at the next edge, and a 1 in `sw_clr[i]` clears it. When both are 1 for the same bit, the flag ends up 1. `flags` shows the flag register.
- R4: An event edge and a `sw_clr` pulse on the same bit in the same cycle leave that flag at 1.
- R5: `en_we` loads `en_data` into `enables` at the next edge. A flagged source whose enable bit is 0 is never offered, and its flag stays pending.
- R6: `gie_set` sets `gie`, and `gie_clr` clears it, with `gie_set` taking precedence. No offer is made while `gie` is 0.
- R7: If more than one source is flagged and enabled, `take_id` is the lowest index among them.
- R8: A `branch_issue` pulse sampled at edge E blocks `take_valid` from edge E until edge E+5 (DELAY_SLOTS = 5). Flags are not changed by the block, and the offer comes back after edge E+5 if the conditions still hold.
- R9: When branches are issued every 5 cycles or more often, no offer is ever made. A period of 6 cycles opens one offer cycle per period.
- R10: A transfer (`take_valid` and `take_ready` both 1) clears the flag of `take_id` and clears `gie` at the next edge, unless `gie_set` is 1 in the same cycle, in which case `gie` stays 1.
- R11: `take_valid` is 1 exactly when `gie` is 1, no branch is in its delay slots, and at least one source is both flagged and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | N_SRC | Hardware event lines; a rising edge latches the flag |
| sw_set | input | N_SRC | Write-one-to-set strobes for the flags |
| sw_clr | input | N_SRC | Write-one-to-clear strobes for the flags |
| en_we | input | 1 | Load strobe for the enable register |
| en_data | input | N_SRC | New enable register value |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| branch_issue | input | 1 | Core issued a branch this cycle |
| take_ready | input | 1 | Core accepts the offered interrupt |
| take_valid | output | 1 | An interrupt is offered |
| take_id | output | IDW | Index of the offered source |
| flags | output | N_SRC | Flag register readback |
| enables | output | N_SRC | Enable register readback |
| gie | output | 1 | Global enable readback |

## Verification
The hardest case to reach from the ports is the edge of the branch window. A loop whose branch period is one cycle below or exactly at the slot count plus one must either always stay blocked or open exactly one cycle. The bench drives directed branch trains with periods of 5 and 6 cycles while an eligible flag waits. It also drives random branch pulses that land against acknowledges and against set and clear collisions. A cycle-accurate reference model in the bench checks every output after every edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned DEF_SOURCES     = 8;
  parameter int unsigned DEF_DELAY_SLOTS = 5;

  typedef enum logic [1:0] {
    GIE_KEEP = 2'd0,
    GIE_ON   = 2'd1,
    GIE_OFF  = 2'd2
  } gie_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = irq_pkg::DEF_SOURCES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] sw_set,
  input  logic [N_SRC-1:0] sw_clr,
  input  logic [N_SRC-1:0] ack_mask,
  output logic [N_SRC-1:0] flags
);
  logic [N_SRC-1:0] evt_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] flags_d;

  // per-bit: any set source beats any clear source
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign rise[i] = evt[i] & ~evt_q[i];
    always_comb begin
      if (sw_set[i] || rise[i])
        flags_d[i] = 1'b1;
      else if (sw_clr[i] || ack_mask[i])
        flags_d[i] = 1'b0;
      else
        flags_d[i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      flags <= '0;
    end else begin
      evt_q <= evt;
      flags <= flags_d;
    end
  end
endmodule

// File: rtl/irq_branch_gate.sv
module irq_branch_gate #(
  parameter int unsigned DELAY_SLOTS = irq_pkg::DEF_DELAY_SLOTS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic branch_issue,
  output logic busy
);
  localparam int unsigned CW = $clog2(DELAY_SLOTS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY_SLOTS);

  logic [CW-1:0] slots_left;

  always_ff @(posedge clk) begin
    if (!rst_n)
      slots_left <= '0;
    else if (branch_issue)
      slots_left <= RELOAD;
    else if (slots_left != '0)
      slots_left <= slots_left - 1'b1;
  end

  assign busy = (slots_left != '0);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = irq_pkg::DEF_SOURCES,
  parameter int unsigned IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDW-1:0]   id,
  output logic [N_SRC-1:0] grant
);
  always_comb begin
    id    = '0;
    grant = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        id    = IDW'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned N_SRC       = irq_pkg::DEF_SOURCES,
  parameter int unsigned DELAY_SLOTS = irq_pkg::DEF_DELAY_SLOTS,
  parameter int unsigned IDW         = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] sw_set,
  input  logic [N_SRC-1:0] sw_clr,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_data,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             branch_issue,
  input  logic             take_ready,
  output logic             take_valid,
  output logic [IDW-1:0]   take_id,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] enables,
  output logic             gie
);
  import irq_pkg::*;

  logic             busy;
  logic             any_ready;
  logic [N_SRC-1:0] grant;
  logic [N_SRC-1:0] ack_mask;
  logic             xfer;
  gie_op_e          gie_op;

  irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sw_set(sw_set),
    .sw_clr(sw_clr), .ack_mask(ack_mask), .flags(flags)
  );

  irq_branch_gate #(.DELAY_SLOTS(DELAY_SLOTS)) u_gate (
    .clk(clk), .rst_n(rst_n), .branch_issue(branch_issue), .busy(busy)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .IDW(IDW)) u_pick (
    .req(flags & enables), .any(any_ready), .id(take_id), .grant(grant)
  );

  assign take_valid = gie & ~busy & any_ready;
  assign xfer       = take_valid & take_ready;
  assign ack_mask   = grant & {N_SRC{xfer}};

  always_comb begin
    if (gie_set)
      gie_op = GIE_ON;
    else if (gie_clr || xfer)
      gie_op = GIE_OFF;
    else
      gie_op = GIE_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables <= '0;
      gie     <= 1'b0;
    end else begin
      if (en_we)
        enables <= en_data;
      case (gie_op)
        GIE_ON:  gie <= 1'b1;
        GIE_OFF: gie <= 1'b0;
        default: gie <= gie;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] sw_set,
  input logic             gie_set,
  input logic             branch_issue,
  input logic             take_ready,
  input logic             take_valid,
  input logic [IDW-1:0]   take_id,
  input logic [N_SRC-1:0] flags,
  input logic [N_SRC-1:0] enables,
  input logic             gie
);
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] below;
  assign elig  = flags & enables;
  assign below = (N_SRC'(1) << take_id) - N_SRC'(1);

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(sw_set)) == $past(sw_set)));

  assert_offer_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (gie && flags[take_id] && enables[take_id]));

  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> ((elig & below) == '0));

  assert_branch_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_issue |=> !take_valid);

  assert_ack_drops_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready && !gie_set) |=> !gie);

  assert_gie_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !take_valid);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .gie_set(gie_set),
  .branch_issue(branch_issue), .take_ready(take_ready),
  .take_valid(take_valid), .take_id(take_id), .flags(flags),
  .enables(enables), .gie(gie)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int SLOTS = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] evt = '0, sw_set = '0, sw_clr = '0, en_data = '0;
  logic en_we = 0, gie_set = 0, gie_clr = 0, branch_issue = 0, take_ready = 0;
  logic take_valid, gie;
  logic [IW-1:0] take_id;
  logic [N-1:0] flags, enables;

  int total = 0, bad = 0;

  // reference model state
  logic [N-1:0] m_flags = '0, m_en = '0, m_prev = '0;
  logic m_gie = 0;
  int m_cnt = 0;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sw_set(sw_set), .sw_clr(sw_clr),
    .en_we(en_we), .en_data(en_data), .gie_set(gie_set), .gie_clr(gie_clr),
    .branch_issue(branch_issue), .take_ready(take_ready),
    .take_valid(take_valid), .take_id(take_id), .flags(flags),
    .enables(enables), .gie(gie)
  );

  always #4 clk = ~clk;

  function automatic logic m_valid();
    return m_gie && (m_cnt == 0) && ((m_flags & m_en) != '0);
  endfunction

  function automatic int m_id();
    for (int i = 0; i < N; i++) if (m_flags[i] & m_en[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic hs;
    logic [N-1:0] ackm;
    hs = m_valid() && take_ready;
    ackm = hs ? (N'(1) << m_id()) : '0;
    m_flags = (m_flags & ~sw_clr & ~ackm) | sw_set | (evt & ~m_prev);
    m_prev = evt;
    if (en_we) m_en = en_data;
    if (gie_set) m_gie = 1;
    else if (gie_clr || hs) m_gie = 0;
    if (branch_issue) m_cnt = SLOTS;
    else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic compare_all();
    chk("R3 flags", 32'(flags), 32'(m_flags));
    chk("R5 enables", 32'(enables), 32'(m_en));
    chk("R6 gie", 32'(gie), 32'(m_gie));
    chk("R11 take_valid", 32'(take_valid), 32'(m_valid()));
    if (m_valid()) chk("R7 take_id", 32'(take_id), 32'(m_id()));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    sw_set = '0; sw_clr = '0; en_we = 0; gie_set = 0; gie_clr = 0;
    branch_issue = 0; take_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nval;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", 32'(flags), 0);
    chk("R1 enables", 32'(enables), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 take_valid", 32'(take_valid), 0);

    // enable all, global enable
    en_we = 1; en_data = '1; gie_set = 1; cycle(); idle();
    // R3 set lands, R11 offer
    sw_set = 8'h08; cycle(); idle();
    chk("R3 set", 32'(flags), 32'h08);
    chk("R11 offer", 32'(take_valid), 1);
    chk("R11 id", 32'(take_id), 3);
    // R3 set vs clear same bit
    sw_set = 8'h08; sw_clr = 8'h08; cycle(); idle();
    chk("R3 set wins", 32'(flags[3]), 1);
    sw_clr = 8'h08; cycle(); idle();
    chk("R3 clear", 32'(flags), 0);
    // R4 event edge vs clear same cycle
    evt = 8'h10; sw_clr = 8'h10; cycle(); idle();
    chk("R4 edge beats clear", 32'(flags[4]), 1);
    // R2 held level does not re-set
    sw_clr = 8'h10; cycle(); idle();
    cycle(); cycle();
    chk("R2 held level", 32'(flags[4]), 0);
    evt = 8'h00; cycle(); evt = 8'h10; cycle();
    chk("R2 new edge", 32'(flags[4]), 1);
    evt = 8'h00; sw_clr = '1; cycle(); idle();
    // R5 disabled source stays pending
    en_we = 1; en_data = 8'hFE; sw_set = 8'h01; cycle(); idle();
    cycle();
    chk("R5 pending flag", 32'(flags[0]), 1);
    chk("R5 not offered", 32'(take_valid), 0);
    en_we = 1; en_data = '1; sw_clr = 8'h01; cycle(); idle();
    // R6 gie gates
    gie_clr = 1; sw_set = 8'h40; cycle(); idle();
    chk("R6 gie off no offer", 32'(take_valid), 0);
    gie_set = 1; gie_clr = 1; cycle(); idle();
    chk("R6 set beats clear", 32'(gie), 1);
    sw_clr = 8'h40; cycle(); idle();
    // R7 priority
    sw_set = 8'h24; cycle(); idle();
    chk("R7 lowest", 32'(take_id), 2);
    // R10 transfer
    take_ready = 1; cycle(); idle();
    chk("R10 flag cleared", 32'(flags), 32'h20);
    chk("R10 gie cleared", 32'(gie), 0);
    chk("R10 no offer", 32'(take_valid), 0);
    gie_set = 1; cycle(); idle();
    chk("R7 next id", 32'(take_id), 5);
    take_ready = 1; gie_set = 1; cycle(); idle();
    chk("R10 set keeps gie", 32'(gie), 1);
    chk("R10 flag5 cleared", 32'(flags[5]), 0);
    // R8 branch window
    sw_set = 8'h02; cycle(); idle();
    branch_issue = 1; cycle(); idle();
    chk("R8 blocked E0", 32'(take_valid), 0);
    for (int i = 0; i < SLOTS - 1; i++) begin
      cycle();
      chk("R8 blocked slot", 32'(take_valid), 0);
    end
    chk("R8 flag kept", 32'(flags[1]), 1);
    cycle();
    chk("R8 offer returns", 32'(take_valid), 1);
    // R9 period 5 loop never interruptible
    for (int k = 0; k < 30; k++) begin
      branch_issue = (k % 5 == 0); cycle();
      chk("R9 period5 blocked", 32'(take_valid), 0);
    end
    // R9 period 6 opens
    nval = 0;
    for (int k = 0; k < 30; k++) begin
      branch_issue = (k % 6 == 0); cycle();
      if (take_valid) nval++;
    end
    idle();
    chk("R9 period6 windows", 32'(nval), 5);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      evt = N'($urandom) & N'($urandom);
      sw_set = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      sw_clr = (($urandom % 4) == 0) ? N'($urandom) : '0;
      en_we = (($urandom % 16) == 0);
      en_data = N'($urandom) | N'($urandom);
      gie_set = (($urandom % 3) == 0);
      gie_clr = (($urandom % 10) == 0);
      branch_issue = (($urandom % 7) == 0);
      take_ready = $urandom % 2;
      cycle();
    end
    idle();
    cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule